// File: doc/BRIEF.md
# Sixteen-Bit Accumulator Processor Core

This block is a small multicycle processor built around one 16-bit accumulator. It reads each 16-bit instruction from a byte-addressed memory through a single port and executes it over several clock cycles. Every operand is direct: an instruction carries a 10-bit field that is either an immediate value or a byte address. The core keeps four registers: the program counter, an address-out register that drives the memory address, a data-in register that holds the fetched instruction, and the accumulator.

Memory is reached through an address bus, separate write and read data buses, and a two-bit operation code. A read returns its data on the clock after the request. A write takes effect on the edge at which it is requested. Each instruction is two bytes long, so sequential fetch steps the program counter by 2. The program counter can be loaded with a target and stepped past it in the same cycle. This means the address-out register already holds the next instruction's address whenever a fetch begins.

An instruction word has these fields: bit 15 is an addressing-mode flag that the core ignores, bits 14..10 are the opcode, and bits 9..0 are the operand field X.

Top module: `acc_core`

## Requirements
- R1: While reset is low and in the first cycle after its release, mem_op is NOP (00). The first fetch is a read (01) of byte address 0 in the second cycle after release. The accumulator starts at 0.
- R2: An instruction's cycles are: a fetch read at the current program address, one NOP cycle, and then its execute cycles. Without a branch, the next fetch address is the previous one plus 2, modulo 1024.
- R3: Opcode 00000 sets AC to its bitwise complement. Opcode 00001 shifts AC right logically by one bit and puts 0 into bit 15. Each takes 3 cycles from fetch to the next fetch.
- R4: Opcode 00110 sets AC to AC AND X, and opcode 00111 sets AC to AC + X modulo 2^16. In both cases X is zero-extended to 16 bits, and each takes 3 cycles.
- R5: Opcode 00101 (load) takes 5 cycles: fetch, NOP, NOP, a read of byte address X, and NOP. AC then takes the word that the read returned.
- R6: Opcode 00100 (store) takes 4 cycles: fetch, NOP, NOP, and a write (10) of AC to byte address X on mem_wdata. The next cycle is a fetch.
- R7: Opcode 00010 takes 3 cycles. If AC bit 15 is 1, the next fetch is at X. Otherwise the next fetch is at the next sequential address.
- R8: Opcode 00011 takes 3 cycles, and the next fetch is always at X.
- R9: Instruction bit 15 has no effect on any instruction.
- R10: An opcode whose bits 14..13 are not 00 behaves as a 3-cycle no-operation. AC is unchanged and fetch continues at the next sequential address.
- R11: mem_op only takes the values NOP = 00, read = 01 and write = 10, and never 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mem_addr | output | 10 | Byte address of the memory access (the address-out register) |
| mem_op | output | 2 | Memory operation: 00 NOP, 01 read, 10 write |
| mem_wdata | output | 16 | Write data (the accumulator) |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |

## Verification
Every bus cycle is a function of the accumulator, the program counter and the state. A corrupted accumulator therefore shows up at the latest on the next store, as a wrong mem_wdata, or on the next sign branch, as a wrong fetch address three cycles after that branch's fetch. A wrong program counter or state is seen within one instruction, because the bench predicts the operation code and address of every cycle from an instruction-level model and compares them on every clock. Skipped stores and untaken paths are confirmed by preset memory words that must keep their values.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int OPC_W = 5;

  typedef enum logic [3:0] {
    S_BOOT, S_FETCH, S_LATCH, S_ALU, S_LD1, S_LD2, S_LD3,
    S_ST1, S_ST2, S_BRN, S_JMP
  } cpu_state_e;

  typedef enum logic [1:0] {
    MOP_IDLE = 2'b00,
    MOP_RD   = 2'b01,
    MOP_WR   = 2'b10
  } mem_op_e;

  typedef enum logic [2:0] {
    ALU_PASS = 3'd0,
    ALU_NOT  = 3'd1,
    ALU_AND  = 3'd2,
    ALU_ADD  = 3'd3,
    ALU_SHR  = 3'd4
  } alu_op_e;

  localparam logic [OPC_W-1:0] OPC_CPL  = 5'b00000;
  localparam logic [OPC_W-1:0] OPC_SHR  = 5'b00001;
  localparam logic [OPC_W-1:0] OPC_BNEG = 5'b00010;
  localparam logic [OPC_W-1:0] OPC_JMP  = 5'b00011;
  localparam logic [OPC_W-1:0] OPC_ST   = 5'b00100;
  localparam logic [OPC_W-1:0] OPC_LD   = 5'b00101;
  localparam logic [OPC_W-1:0] OPC_AND  = 5'b00110;
  localparam logic [OPC_W-1:0] OPC_ADD  = 5'b00111;

  typedef struct packed {
    mem_op_e mop;
    alu_op_e alu;
    logic    ac_le;
    logic    di_le;
    logic    ao_le;
    logic    ao_x;
    logic    a_mem;
    logic    pc_ld;
    logic    pc_inc;
  } ctl_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);

  always_comb begin
    case (op)
      ALU_PASS: y = a;
      ALU_NOT:  y = ~b;
      ALU_AND:  y = a & b;
      ALU_ADD:  y = a + b;
      ALU_SHR:  y = {1'b0, b[W-1:1]};
      default:  y = b;
    endcase
  end

endmodule

// File: rtl/acc_pc.sv
module acc_pc #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic          inc,
  input  logic [AW-1:0] tgt,
  output logic [AW-1:0] pc
);

  localparam logic [AW-1:0] STEP = AW'(2);

  logic [AW-1:0] pc_d;

  // a load steps past the target in the same cycle
  always_comb begin
    if (ld)       pc_d = tgt + STEP;
    else if (inc) pc_d = pc + STEP;
    else          pc_d = pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_d;
  end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] fetch_opc,
  input  logic [OPC_W-1:0] di_opc,
  input  logic             ac_neg,
  output ctl_t             ctl,
  output cpu_state_e       st
);

  cpu_state_e st_d;

  always_comb begin
    ctl  = '0;
    st_d = st;
    case (st)
      S_BOOT: begin
        ctl.ao_le  = 1'b1;
        ctl.pc_inc = 1'b1;
        st_d       = S_FETCH;
      end
      S_FETCH: begin
        ctl.mop = MOP_RD;
        st_d    = S_LATCH;
      end
      S_LATCH: begin
        ctl.di_le = 1'b1;
        case (fetch_opc)
          OPC_BNEG: st_d = S_BRN;
          OPC_JMP:  st_d = S_JMP;
          OPC_ST:   st_d = S_ST1;
          OPC_LD:   st_d = S_LD1;
          default:  st_d = S_ALU;
        endcase
      end
      S_ALU: begin
        ctl.ao_le  = 1'b1;
        ctl.pc_inc = 1'b1;
        ctl.ac_le  = 1'b1;
        st_d       = S_FETCH;
        case (di_opc)
          OPC_CPL: ctl.alu = ALU_NOT;
          OPC_SHR: ctl.alu = ALU_SHR;
          OPC_AND: ctl.alu = ALU_AND;
          OPC_ADD: ctl.alu = ALU_ADD;
          default: ctl.ac_le = 1'b0;
        endcase
      end
      S_LD1: begin
        ctl.ao_le = 1'b1;
        ctl.ao_x  = 1'b1;
        st_d      = S_LD2;
      end
      S_LD2: begin
        ctl.mop = MOP_RD;
        st_d    = S_LD3;
      end
      S_LD3: begin
        ctl.a_mem  = 1'b1;
        ctl.alu    = ALU_PASS;
        ctl.ac_le  = 1'b1;
        ctl.ao_le  = 1'b1;
        ctl.pc_inc = 1'b1;
        st_d       = S_FETCH;
      end
      S_ST1: begin
        ctl.ao_le = 1'b1;
        ctl.ao_x  = 1'b1;
        st_d      = S_ST2;
      end
      S_ST2: begin
        ctl.mop    = MOP_WR;
        ctl.ao_le  = 1'b1;
        ctl.pc_inc = 1'b1;
        st_d       = S_FETCH;
      end
      S_BRN: begin
        ctl.ao_le  = 1'b1;
        ctl.ao_x   = ac_neg;
        ctl.pc_ld  = ac_neg;
        ctl.pc_inc = !ac_neg;
        st_d       = S_FETCH;
      end
      S_JMP: begin
        ctl.ao_le = 1'b1;
        ctl.ao_x  = 1'b1;
        ctl.pc_ld = 1'b1;
        st_d      = S_FETCH;
      end
      default: st_d = S_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_BOOT;
    else        st <= st_d;
  end

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_op,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int OPC_LSB = ADDR_W;
  localparam int OPC_MSB = ADDR_W + OPC_W - 1;
  localparam int SIGN    = DATA_W - 1;

  ctl_t              ctl;
  cpu_state_e        st;
  logic [ADDR_W-1:0] pc_q, ao_q, ao_d, x_fld;
  logic [DATA_W-1:0] di_q, di_d, ac_q, ac_d, a_bus, alu_y;

  assign x_fld = di_q[ADDR_W-1:0];
  assign a_bus = ctl.a_mem ? mem_rdata : {{(DATA_W-ADDR_W){1'b0}}, x_fld};

  acc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_opc (mem_rdata[OPC_MSB:OPC_LSB]),
    .di_opc    (di_q[OPC_MSB:OPC_LSB]),
    .ac_neg    (ac_q[SIGN]),
    .ctl       (ctl),
    .st        (st)
  );

  acc_pc #(.AW(ADDR_W)) u_pc (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (ctl.pc_ld),
    .inc   (ctl.pc_inc),
    .tgt   (x_fld),
    .pc    (pc_q)
  );

  acc_alu #(.W(DATA_W)) u_alu (
    .op (ctl.alu),
    .a  (a_bus),
    .b  (ac_q),
    .y  (alu_y)
  );

  always_comb begin
    di_d = ctl.di_le ? mem_rdata : di_q;
    ac_d = ctl.ac_le ? alu_y     : ac_q;
    ao_d = ao_q;
    if (ctl.ao_le) ao_d = ctl.ao_x ? x_fld : pc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      di_q <= '0;
      ac_q <= '0;
      ao_q <= '0;
    end else begin
      di_q <= di_d;
      ac_q <= ac_d;
      ao_q <= ao_d;
    end
  end

  assign mem_addr  = ao_q;
  assign mem_op    = ctl.mop;
  assign mem_wdata = ac_q;

  a_r11_bus_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mem_op != 2'b11);

  a_r2_read_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_op == MOP_RD |=> mem_op == MOP_IDLE);

  a_r6_write_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    mem_op == MOP_WR |=> (mem_op == MOP_RD && mem_addr == $past(pc_q)));

  a_r7_untaken_falls_through: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BRN && !ac_q[SIGN]) |=> mem_addr == $past(pc_q));

  a_r3_shift_fills_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ALU && di_q[OPC_MSB:OPC_LSB] == OPC_SHR) |=> !ac_q[SIGN]);

endmodule

// File: tb/tb_acc_core.sv
module tb_acc_core;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  mem_addr;
  logic [1:0]  mem_op;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;

  always #5 clk = ~clk;

  acc_core dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_op    (mem_op),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  logic [15:0] img [512];
  logic [15:0] bmem[512];
  logic [15:0] mm  [512];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [1:0]  q_op[$];
  logic [9:0]  q_addr[$];
  logic [15:0] q_data[$];
  string       q_tag[$];

  // bench memory: image loaded while in reset, read data one cycle late
  always @(posedge clk) begin
    if (!rst_n) begin
      bmem      <= img;
      mem_rdata <= '0;
    end else if (mem_op == 2'b01) begin
      mem_rdata <= bmem[mem_addr[9:1]];
    end else if (mem_op == 2'b10) begin
      bmem[mem_addr[9:1]] <= mem_wdata;
    end
  end

  function automatic logic [15:0] enc(bit ib, logic [4:0] op, logic [9:0] x);
    return {ib, op, x};
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(logic [1:0] op, logic [9:0] a, logic [15:0] d, string tag);
    q_op.push_back(op);
    q_addr.push_back(a);
    q_data.push_back(d);
    q_tag.push_back(tag);
  endtask

  // instruction-level reference model producing the expected bus per cycle
  task automatic model_run(int n);
    logic [9:0]  pc = '0;
    logic [15:0] ac = '0;
    push(2'b00, '0, '0, "R1");
    for (int k = 0; k < n; k++) begin
      logic [15:0] w = mm[pc[9:1]];
      logic [4:0]  op = w[14:10];
      logic [9:0]  x  = w[9:0];
      string       t;
      push(2'b01, pc, '0, (k == 0) ? "R1" : "R2");
      push(2'b00, '0, '0, "R2");
      pc = pc + 10'd2;
      case (op)
        5'b00000: begin ac = ~ac;                 t = "R3"; end
        5'b00001: begin ac = ac >> 1;             t = "R3"; end
        5'b00110: begin ac = ac & {6'b0, x};      t = "R4"; end
        5'b00111: begin ac = ac + {6'b0, x};      t = "R4"; end
        5'b00010: begin if (ac[15]) pc = x;        t = "R7"; end
        5'b00011: begin pc = x;                    t = "R8"; end
        5'b00100: t = "R6";
        5'b00101: t = "R5";
        default:  t = "R10";
      endcase
      if (w[15]) t = "R9";
      if (op == 5'b00100) begin
        push(2'b00, '0, '0, t);
        push(2'b10, x, ac, t);
        mm[x[9:1]] = ac;
      end else if (op == 5'b00101) begin
        push(2'b00, '0, '0, t);
        push(2'b01, x, '0, t);
        push(2'b00, '0, '0, t);
        ac = mm[x[9:1]];
      end else begin
        push(2'b00, '0, '0, t);
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) img[i] = '0;
    img[0]  = enc(0, 5'b00110, 10'd0);
    img[1]  = enc(0, 5'b00111, 10'h3F5);
    img[2]  = enc(0, 5'b00100, 10'd600);
    img[3]  = enc(0, 5'b00000, 10'd0);
    img[4]  = enc(0, 5'b00100, 10'd602);
    img[5]  = enc(0, 5'b00001, 10'd0);
    img[6]  = enc(0, 5'b00100, 10'd604);
    img[7]  = enc(0, 5'b00101, 10'd700);
    img[8]  = enc(0, 5'b00010, 10'd24);
    img[9]  = enc(0, 5'b00100, 10'd606);
    img[12] = enc(0, 5'b00001, 10'd0);
    img[13] = enc(0, 5'b00010, 10'd40);
    img[14] = enc(1, 5'b00111, 10'd5);
    img[15] = enc(0, 5'b11000, 10'd1);
    img[16] = enc(0, 5'b00100, 10'd608);
    img[17] = enc(0, 5'b00101, 10'd702);
    img[18] = enc(0, 5'b00111, 10'd1);
    img[19] = enc(0, 5'b00100, 10'd610);
    img[20] = enc(0, 5'b00011, 10'd50);
    img[21] = enc(0, 5'b00100, 10'd612);
    img[25] = enc(0, 5'b00111, 10'h2AB);
    img[26] = enc(0, 5'b00110, 10'h0F0);
    img[27] = enc(0, 5'b00100, 10'd614);
    img[28] = enc(0, 5'b00011, 10'd56);
    img[303] = 16'h5555;
    img[305] = 16'h1234;
    img[306] = 16'h6666;
    img[350] = 16'h8001;
    img[351] = 16'hFFFF;
    mm = img;
    model_run(30);

    rst_n = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(mem_op == 2'b00, "R1", "mem_op in reset", int'(mem_op), 0);
    end
    rst_n = 1'b1;

    while (q_op.size() > 0) begin
      logic [1:0]  eop;
      logic [9:0]  ea;
      logic [15:0] ed;
      string       et;
      #1;
      eop = q_op.pop_front();
      ea  = q_addr.pop_front();
      ed  = q_data.pop_front();
      et  = q_tag.pop_front();
      chk(mem_op == eop, et, "mem_op (R11 codes)", int'(mem_op), int'(eop));
      if (eop != 2'b00)
        chk(mem_addr == ea, et, "mem_addr", int'(mem_addr), int'(ea));
      if (eop == 2'b10)
        chk(mem_wdata == ed, et, "mem_wdata", int'(mem_wdata), int'(ed));
      @(negedge clk);
    end

    chk(bmem[300] == 16'h03F5, "R4", "add immediate result", int'(bmem[300]), 'h03F5);
    chk(bmem[301] == 16'hFC0A, "R3", "complement result", int'(bmem[301]), 'hFC0A);
    chk(bmem[302] == 16'h7E05, "R3", "shift result", int'(bmem[302]), 'h7E05);
    chk(bmem[303] == 16'h5555, "R7", "taken branch skipped store", int'(bmem[303]), 'h5555);
    chk(bmem[304] == 16'h4005, "R9", "flag bit ignored", int'(bmem[304]), 'h4005);
    chk(bmem[304] == 16'h4005, "R10", "undefined opcode kept AC", int'(bmem[304]), 'h4005);
    chk(bmem[305] == 16'h0000, "R4", "add wraps to zero", int'(bmem[305]), 0);
    chk(bmem[306] == 16'h6666, "R8", "jump skipped store", int'(bmem[306]), 'h6666);
    chk(bmem[307] == 16'h00A0, "R4", "and immediate result", int'(bmem[307]), 'h00A0);
    chk(bmem[350] == 16'h8001, "R5", "load source intact", int'(bmem[350]), 'h8001);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule